// File: doc/BRIEF.md
# Big-endian byte and word load/store aligner

This block sits between a 32-bit integer core and a data memory that is one word wide. For every memory operation it forms the effective byte address from a base register and a signed 16-bit displacement. It then maps that address onto the word-wide memory using big-endian lane numbering, where the byte at the lowest address is the most significant byte of the word.

For a load, the block takes the memory read word and returns the loaded value. A byte load picks the addressed lane, places it in the low end of the result and sign- or zero-extends it. A word load passes the word through. For a store, the block produces the write word and four byte-lane write enables. A byte store copies the low register byte onto every lane and enables only the addressed lane.

A word access that is not on a 4-byte boundary is flagged as misaligned and writes nothing. The combinational load result is also captured in a register, so it is available again one cycle after the read.

Top module: `beLsAlign`

## Requirements
- R1: `memAddr` equals `baseAddr` plus `offsetImm` sign-extended to 32 bits, modulo 2^32, in the same cycle.
- R2: An aligned word load (opcode 35) returns `memRdata` unchanged on `loadResult`.
- R3: A signed byte load (opcode 32) returns the byte at offset `memAddr[1:0]`, sign-extended. Offset 0 selects `memRdata[31:24]`, 1 selects `[23:16]`, 2 selects `[15:8]` and 3 selects `[7:0]`.
- R4: An unsigned byte load (opcode 36) returns the same byte lane as R3, zero-extended to 32 bits.
- R5: A byte store (opcode 40) drives `memWdata` with `storeData[7:0]` copied into all four lanes. `byteEn` is one-hot: offset 0 sets bit 3, 1 sets bit 2, 2 sets bit 1 and 3 sets bit 0.
- R6: An aligned word store (opcode 43) drives `memWdata` equal to `storeData` and `byteEn` equal to 4'b1111.
- R7: A word load or word store whose `memAddr[1:0]` is not zero raises `misalign`, drives `byteEn` to zero and returns zero on `loadResult`.
- R8: Byte operations never raise `misalign`, whatever the address.
- R9: With `opValid` low, or with any other opcode, `byteEn`, `memWdata`, `loadResult` and `misalign` are all zero.
- R10: One cycle after a completed load (valid, recognised, not misaligned), `loadValidQ` is 1 and `loadResultQ` holds that load's `loadResult`. After any other cycle, `loadValidQ` is 0 and `loadResultQ` keeps its value.
- R11: While `rstN` is low, `loadValidQ` and `loadResultQ` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 6 | Primary opcode of the memory operation |
| baseAddr | input | 32 | Base register value |
| offsetImm | input | 16 | Signed displacement |
| storeData | input | 32 | Register value to store |
| memRdata | input | 32 | Word read from memory |
| memAddr | output | 32 | Effective byte address |
| memWdata | output | 32 | Word written to memory |
| byteEn | output | 4 | Byte-lane write enables, bit 3 = lowest address |
| loadResult | output | 32 | Aligned and extended load value |
| misalign | output | 1 | Unaligned word access |
| loadResultQ | output | 32 | Load value registered one cycle later |
| loadValidQ | output | 1 | `loadResultQ` was updated at the last edge |

## Verification
Byte loads are tried at all four offsets against a read word whose lanes alternate between a set and a clear sign bit (0x80, 0x7F, 0xC3, 0x05). This separates sign extension from zero extension and shows which lane was chosen. Byte stores at every offset use a register whose upper bytes differ from its low byte, which exposes both the lane order of the enables and any failure to copy the low byte. Word accesses are run at each unaligned offset and next to byte accesses at those same addresses, to tell the misalignment rule apart from the lane logic. Back-to-back loads, followed by a non-load, show whether the registered copy updates only after a completed load.

// File: rtl/lsAlignPkg.sv
package lsAlignPkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_LOAD_BYTE  = 6'd32;
  localparam logic [OPC_W-1:0] OP_LOAD_WORD  = 6'd35;
  localparam logic [OPC_W-1:0] OP_LOAD_UBYTE = 6'd36;
  localparam logic [OPC_W-1:0] OP_STORE_BYTE = 6'd40;
  localparam logic [OPC_W-1:0] OP_STORE_WORD = 6'd43;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic doLoad;
    logic doStore;
    logic wordSize;
    logic signExt;
    logic misalign;
  } lsStrobes_t;
endpackage

// File: rtl/lsCtrl.sv
module lsCtrl
  import lsAlignPkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  input  logic [OFS_W-1:0] laneOfs,
  output lsStrobes_t       strobes
);
  logic isLoad, isStore, isWord, isSigned;

  always_comb begin
    isLoad   = 1'b0;
    isStore  = 1'b0;
    isWord   = 1'b0;
    isSigned = 1'b0;
    if (opValid) begin
      unique case (opCode)
        OP_LOAD_WORD:  begin isLoad = 1'b1; isWord = 1'b1; end
        OP_LOAD_BYTE:  begin isLoad = 1'b1; isSigned = 1'b1; end
        OP_LOAD_UBYTE: begin isLoad = 1'b1; end
        OP_STORE_WORD: begin isStore = 1'b1; isWord = 1'b1; end
        OP_STORE_BYTE: begin isStore = 1'b1; end
        default:       ;
      endcase
    end
  end

  always_comb begin
    strobes.doLoad   = isLoad;
    strobes.doStore  = isStore;
    strobes.wordSize = isWord;
    strobes.signExt  = isSigned;
    // only word-sized accesses care about the low address bits
    strobes.misalign = isWord && (isLoad || isStore) && (laneOfs != '0);
  end
endmodule

// File: rtl/lsDatapath.sv
module lsDatapath
  import lsAlignPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [IMM_W-1:0]            offsetImm,
  input  logic [DATA_W-1:0]           storeData,
  input  logic [DATA_W-1:0]           memRdata,
  input  lsStrobes_t                  strobes,
  output logic [ADDR_W-1:0]           effAddr,
  output logic [DATA_W-1:0]           memWdata,
  output logic [DATA_W/LANE_W-1:0]    byteEn,
  output logic [DATA_W-1:0]           loadResult,
  output logic [DATA_W-1:0]           loadResultQ,
  output logic                        loadValidQ
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int OFS_W = $clog2(LANES);
  localparam int EXT_W = DATA_W - LANE_W;

  logic [OFS_W-1:0]  laneOfs;
  logic [LANE_W-1:0] laneBytes [LANES];
  logic [LANES-1:0]  laneEnByOfs;
  logic [LANE_W-1:0] pickedByte;
  logic [EXT_W-1:0]  extBits;
  logic              loadDone;

  // effective address: base plus sign-extended displacement
  assign effAddr = baseAddr + {{(ADDR_W-IMM_W){offsetImm[IMM_W-1]}}, offsetImm};
  assign laneOfs = effAddr[OFS_W-1:0];

  // big-endian lanes: offset k lives in the k-th most significant byte
  for (genvar k = 0; k < LANES; k++) begin : gLane
    assign laneBytes[k] = memRdata[DATA_W-1-k*LANE_W -: LANE_W];
    assign laneEnByOfs[LANES-1-k] = (laneOfs == OFS_W'(k));
  end

  assign pickedByte = laneBytes[laneOfs];
  assign extBits    = strobes.signExt ? {EXT_W{pickedByte[LANE_W-1]}} : '0;
  assign loadDone   = strobes.doLoad && !strobes.misalign;

  always_comb begin
    loadResult = '0;
    if (loadDone) begin
      loadResult = strobes.wordSize ? memRdata : {extBits, pickedByte};
    end
  end

  always_comb begin
    memWdata = '0;
    byteEn   = '0;
    if (strobes.doStore) begin
      memWdata = strobes.wordSize ? storeData : {LANES{storeData[LANE_W-1:0]}};
      if (!strobes.misalign) begin
        byteEn = strobes.wordSize ? '1 : laneEnByOfs;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadResultQ <= '0;
      loadValidQ  <= 1'b0;
    end else begin
      loadValidQ <= loadDone;
      if (loadDone) loadResultQ <= loadResult;
    end
  end

  AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doStore && !strobes.wordSize) |-> $onehot(byteEn)); // R5
  AST_LOADQ_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> (loadValidQ && loadResultQ == $past(loadResult))); // R10
  AST_LOADQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loadDone |=> (!loadValidQ && $stable(loadResultQ))); // R10
endmodule

// File: rtl/beLsAlign.sv
module beLsAlign
  import lsAlignPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opValid,
  input  logic [OPC_W-1:0]         opCode,
  input  logic [ADDR_W-1:0]        baseAddr,
  input  logic [IMM_W-1:0]         offsetImm,
  input  logic [DATA_W-1:0]        storeData,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWdata,
  output logic [DATA_W/LANE_W-1:0] byteEn,
  output logic [DATA_W-1:0]        loadResult,
  output logic                     misalign,
  output logic [DATA_W-1:0]        loadResultQ,
  output logic                     loadValidQ
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int OFS_W = $clog2(LANES);

  lsStrobes_t strobes;

  lsCtrl #(.OFS_W(OFS_W)) u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .laneOfs (memAddr[OFS_W-1:0]),
    .strobes (strobes)
  );

  lsDatapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W), .LANE_W(LANE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .baseAddr    (baseAddr),
    .offsetImm   (offsetImm),
    .storeData   (storeData),
    .memRdata    (memRdata),
    .strobes     (strobes),
    .effAddr     (memAddr),
    .memWdata    (memWdata),
    .byteEn      (byteEn),
    .loadResult  (loadResult),
    .loadResultQ (loadResultQ),
    .loadValidQ  (loadValidQ)
  );

  assign misalign = strobes.misalign;

  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (byteEn == '0 && loadResult == '0)); // R7
  AST_BYTE_NEVER_MISALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_LOAD_BYTE || opCode == OP_LOAD_UBYTE ||
                 opCode == OP_STORE_BYTE)) |-> !misalign); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (byteEn == '0 && loadResult == '0 && memWdata == '0 && !misalign)); // R9
endmodule

// File: tb/beLsAlign_bench.sv
module beLsAlign_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  localparam logic [5:0] C_LB = 6'd32, C_LW = 6'd35, C_LBU = 6'd36,
                         C_SB = 6'd40, C_SW = 6'd43;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [5:0]  opCode = '0;
  logic [31:0] baseAddr = '0;
  logic [15:0] offsetImm = '0;
  logic [31:0] storeData = '0;
  logic [31:0] memRdata = '0;
  logic [31:0] memAddr, memWdata, loadResult, loadResultQ;
  logic [3:0]  byteEn;
  logic        misalign, loadValidQ;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] res;
    logic        mis;
    logic        qValid;
    logic [31:0] qRes;
  } expItem_t;

  expItem_t expQ[$];
  logic        modelQValid = 1'b0;
  logic [31:0] modelQRes   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beLsAlign u_beLsAlign (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .baseAddr(baseAddr), .offsetImm(offsetImm), .storeData(storeData),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .byteEn(byteEn), .loadResult(loadResult), .misalign(misalign),
    .loadResultQ(loadResultQ), .loadValidQ(loadValidQ)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one operation and push what the requirements predict
  task automatic doOp(string tag, logic v, logic [5:0] op, logic [31:0] base,
                      logic [15:0] imm, logic [31:0] sd, logic [31:0] rd);
    expItem_t it;
    logic [31:0] ea;
    logic [1:0]  ofs;
    logic [7:0]  lane;
    bit isWordOp, isLd, isSt;
    @(posedge clk);
    #2;
    opValid = v; opCode = op; baseAddr = base; offsetImm = imm;
    storeData = sd; memRdata = rd;
    ea   = base + 32'($signed(imm));
    ofs  = ea[1:0];
    lane = 8'((rd >> (8 * (3 - int'(ofs)))) & 32'hFF);
    isLd = v && (op == C_LB || op == C_LBU || op == C_LW);
    isSt = v && (op == C_SB || op == C_SW);
    isWordOp = (op == C_LW || op == C_SW);
    it.tag = tag; it.addr = ea; it.wdata = '0; it.be = '0; it.res = '0;
    it.mis = (isLd || isSt) && isWordOp && (ofs != 2'd0);
    it.qValid = modelQValid; it.qRes = modelQRes;
    if (isLd && !it.mis) begin
      if (op == C_LW)      it.res = rd;
      else if (op == C_LB) it.res = {{24{lane[7]}}, lane};
      else                 it.res = {24'h0, lane};
    end
    if (isSt) begin
      it.wdata = (op == C_SW) ? sd : {4{sd[7:0]}};
      if (!it.mis) it.be = (op == C_SW) ? 4'hF : (4'b1000 >> ofs);
    end
    expQ.push_back(it);
    modelQValid = isLd && !it.mis;
    if (modelQValid) modelQRes = it.res;
  endtask

  // monitor: compare at the falling edge, away from the capture edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        chk(e.tag, "memAddr R1", memAddr, e.addr);
        chk(e.tag, "memWdata", memWdata, e.wdata);
        chk(e.tag, "byteEn", {28'h0, byteEn}, {28'h0, e.be});
        chk(e.tag, "loadResult", loadResult, e.res);
        chk(e.tag, "misalign", {31'h0, misalign}, {31'h0, e.mis});
        chk("R10", "loadValidQ", {31'h0, loadValidQ}, {31'h0, e.qValid});
        chk("R10", "loadResultQ", loadResultQ, e.qRes);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset loadValidQ", {31'h0, loadValidQ}, 32'h0);
    chk("R11", "reset loadResultQ", loadResultQ, 32'h0);
    @(posedge clk); #2; rstN = 1'b1;

    // R1 R2: aligned word load with negative and positive displacement
    doOp("R2", 1, C_LW, 32'h0000_1010, 16'hFFF0, 32'h0, 32'hDEAD_BEEF);
    doOp("R2", 1, C_LW, 32'hFFFF_FFFC, 16'h0008, 32'h0, 32'h0123_4567);
    // R3: signed byte loads at every lane
    for (int i = 0; i < 4; i++)
      doOp("R3", 1, C_LB, 32'h0000_2000, 16'(i), 32'h0, 32'h807F_C305);
    // R4: unsigned byte loads at every lane
    for (int i = 0; i < 4; i++)
      doOp("R4", 1, C_LBU, 32'h0000_2001, 16'(i - 1), 32'h0, 32'h807F_C305);
    // R5: byte stores at every lane
    for (int i = 0; i < 4; i++)
      doOp("R5", 1, C_SB, 32'h0000_3000 + 32'(i), 16'h0, 32'h1234_56A5, 32'hFFFF_FFFF);
    // R6: aligned word store
    doOp("R6", 1, C_SW, 32'h0000_4000, 16'h0004, 32'hCAFE_F00D, 32'h0);
    // R7: unaligned word loads and stores
    for (int i = 1; i < 4; i++) begin
      doOp("R7", 1, C_LW, 32'h0000_5000, 16'(i), 32'h0, 32'hAAAA_5555);
      doOp("R7", 1, C_SW, 32'h0000_5000, 16'(i), 32'h7777_8888, 32'h0);
    end
    // R8: byte accesses at the same odd addresses stay legal
    doOp("R8", 1, C_LB,  32'h0000_5001, 16'h0, 32'h0, 32'h11F2_3344);
    doOp("R8", 1, C_SB,  32'h0000_5002, 16'h0, 32'h0000_0099, 32'h0);
    doOp("R8", 1, C_LBU, 32'h0000_5003, 16'h0, 32'h0, 32'h1122_33F4);
    // R9: invalid operation and unknown opcode have no effect
    doOp("R9", 0, C_SW, 32'h0000_6000, 16'h0, 32'h1111_1111, 32'h2222_2222);
    doOp("R9", 1, 6'd33, 32'h0000_6000, 16'h0, 32'h3333_3333, 32'h4444_4444);
    // R10: load, load, then non-load so the register holds
    doOp("R10", 1, C_LW, 32'h0000_7000, 16'h0, 32'h0, 32'h5A5A_0001);
    doOp("R10", 1, C_LB, 32'h0000_7003, 16'h0, 32'h0, 32'h0000_00FE);
    doOp("R10", 1, C_SW, 32'h0000_7000, 16'h0, 32'h1, 32'h0);
    doOp("R10", 0, 6'd0, 32'h0, 16'h0, 32'h0, 32'h0);
    doOp("R10", 0, 6'd0, 32'h0, 16'h0, 32'h0, 32'h0);

    while (expQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule